// File: doc/BRIEF.md
# Multi-format serial audio input port

This block is the receiving end of a three-wire serial audio link on which it is always the slave. An external master drives the bit clock, the frame (left/right) clock and the serial data line. The port never drives any of them. All three lines are brought into the system clock domain through a synchronizer chain, and the block acts on bit-clock rising edges that it detects there. Each half-frame yields one 24-bit word, most significant bit first. The word is extracted according to a static two-bit format select: left-justified, I2S-style (one bit of delay) or right-justified.

The frame clock low marks the left half and high marks the right half. A finished stereo pair appears on two parallel outputs with a single-cycle valid strobe. The strobe fires when the right half ends, which is the next high-to-low change of the frame clock. The port supports any frame rate, from 8 kHz up to 192 kHz, provided the system clock is at least about six times the bit-clock frequency.

A watchdog counts system clocks between bit-clock edges. When the bit clock stops, the port mutes itself. It unmutes only after a full frame has arrived on the restored clock. An external mute input also forces silent words.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held and directly after it is released, leftOut and rightOut are zero, sampleValid is low and muteOut is high.
- R2: With fmtSel = 0 (left-justified) or fmtSel = 3 (same behaviour), the word's MSB is the bit sampled on the first bit-clock rise after a frame-clock change, and the next 23 bits follow. Frame clock low carries the left word and high carries the right word.
- R3: With fmtSel = 1 (I2S-style), the MSB is sampled on the second bit-clock rise after a frame-clock change, and the next 23 bits follow.
- R4: With fmtSel = 2 (right-justified), the word is the last 24 bits sampled before the next frame-clock change, for any half-frame length of 24 bit clocks or more.
- R5: Each pair is presented on the system-clock edge that follows detection of the frame clock's high-to-low change. sampleValid is high for exactly one cycle. leftOut and rightOut do not change between strobes.
- R6: When muteIn is high on the cycle a pair is emitted, both emitted words are zero. muteOut is high while muteIn is high.
- R7: When no bit-clock edge is seen for LOSS_CYCLES system clocks, muteOut goes high, and the pairs emitted after that are zero.
- R8: After reset or a bit-clock loss, the first two pairs emitted are zero. muteOut falls together with the strobe of the second pair, and the third pair carries real data.
- R9: In formats 0, 1 and 3, bits beyond the 24-bit window of a half-frame (half-frames longer than 24 or 25 bit clocks) have no effect on the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bclkIn | input | 1 | Bit clock from the external master |
| lrIn | input | 1 | Frame clock, low = left, high = right |
| sdIn | input | 1 | Serial data, MSB first |
| fmtSel | input | 2 | 0 left-justified, 1 I2S-style, 2 right-justified, 3 as 0 |
| muteIn | input | 1 | External mute request |
| leftOut | output | WORD_W | Left word of the last pair |
| rightOut | output | WORD_W | Right word of the last pair |
| sampleValid | output | 1 | One-cycle strobe when a new pair is presented |
| muteOut | output | 1 | Output currently muted (loss, recovery or muteIn) |

## Verification
The checker watches, on every cycle, that the valid strobe lasts a single cycle and that the output words hold between strobes. It also checks that any pair emitted while the mute flag was up is zero, that a stalled bit clock raises the mute flag within a bounded number of cycles, and that the loss-driven mute only drops together with a strobe. The bit positions taken for each format, how the window behaves with long and minimal half-frames, and the count of two frames before unmuting are shown only by the bench. It does this by serializing known words with junk in the unused slots and comparing the decoded pairs.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

  typedef enum logic [1:0] {
    FMT_LEFT     = 2'd0,
    FMT_DELAYED  = 2'd1,
    FMT_RIGHT    = 2'd2,
    FMT_LEFT_ALT = 2'd3
  } fmt_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic restart;   // half-frame boundary: word in shift register is final
    logic firstBit;  // boundary bit belongs to the new word
    logic shiftEn;   // shift the current serial bit in
    logic serBit;    // the synchronized serial bit
    logic saveLeft;  // left half complete
    logic emit;      // right half complete: present the pair
    logic zeroOut;   // present zero words
  } strobe_t;

endpackage

// File: rtl/rxa_sync.sv
module rxa_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  // STAGES must be 2 or more
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxa_watch.sv
module rxa_watch #(
  parameter int LOSS_CYCLES = 1024
) (
  input  logic clk,
  input  logic rstN,
  input  logic bclkS,
  output logic bitRise,
  output logic lost
);
  localparam int CNT_W = $clog2(LOSS_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOSS_V = CNT_W'(LOSS_CYCLES);

  logic             bclkPrev;
  logic [CNT_W-1:0] idleCnt;
  logic             anyEdge;

  assign anyEdge = bclkS ^ bclkPrev;
  assign bitRise = bclkS & ~bclkPrev;
  assign lost    = (idleCnt == LOSS_V);   // R7

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkPrev <= 1'b0;
      idleCnt  <= '0;
    end else begin
      bclkPrev <= bclkS;
      if (anyEdge)               idleCnt <= '0;
      else if (idleCnt != LOSS_V) idleCnt <= idleCnt + 1'b1;
    end
  end
endmodule

// File: rtl/rxa_ctrl.sv
module rxa_ctrl
  import rxa_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitRise,
  input  logic       lost,
  input  logic       lrS,
  input  logic       dataS,
  input  logic [1:0] fmtSel,
  input  logic       muteIn,
  output strobe_t    st,
  output logic       muteOut
);
  localparam int IDX_W = $clog2(WORD_W + 2);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] WORD_IDX = IDX_W'(WORD_W);

  fmt_e             fmt;
  logic             lrPrev;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] curIdx;
  logic             change;
  logic             inWin;
  logic             lossMute;
  logic             recovOne;

  assign fmt    = fmt_e'(fmtSel);
  assign change = bitRise && (lrS != lrPrev);

  // position of the bit sampled at this rise within its half-frame
  always_comb begin
    if (change)                curIdx = '0;
    else if (bitIdx == IDX_MAX) curIdx = IDX_MAX;
    else                       curIdx = bitIdx + 1'b1;
  end

  // format window (R2, R3, R4, R9)
  always_comb begin
    case (fmt)
      FMT_DELAYED: inWin = (curIdx != '0) && (curIdx <= WORD_IDX);
      FMT_RIGHT:   inWin = 1'b1;
      default:     inWin = (curIdx < WORD_IDX);
    endcase
  end

  always_comb begin
    st.restart  = change;
    st.firstBit = (fmt != FMT_DELAYED);
    st.shiftEn  = bitRise && !change && inWin;
    st.serBit   = dataS;
    st.saveLeft = change && !lrPrev;   // left half ended
    st.emit     = change && lrPrev;    // right half ended (R5)
    st.zeroOut  = lossMute || muteIn;  // R6, R7, R8
  end

  assign muteOut = lossMute || muteIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lrPrev <= 1'b0;
      bitIdx <= '0;
    end else if (bitRise) begin
      lrPrev <= lrS;
      bitIdx <= curIdx;
    end
  end

  // loss mute and recovery over two emitted pairs (R7, R8)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lossMute <= 1'b1;
      recovOne <= 1'b0;
    end else if (lost) begin
      lossMute <= 1'b1;
      recovOne <= 1'b0;
    end else if (st.emit && lossMute) begin
      if (recovOne) lossMute <= 1'b0;
      else          recovOne <= 1'b1;
    end
  end
endmodule

// File: rtl/rxa_datapath.sv
module rxa_datapath
  import rxa_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  output logic [WORD_W-1:0] leftOut,
  output logic [WORD_W-1:0] rightOut,
  output logic              sampleValid
);
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] leftHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      leftHold    <= '0;
      leftOut     <= '0;
      rightOut    <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= st.emit;
      if (st.saveLeft) leftHold <= shiftReg;
      if (st.emit) begin
        leftOut  <= st.zeroOut ? '0 : leftHold;
        rightOut <= st.zeroOut ? '0 : shiftReg;
      end
      if (st.restart)
        shiftReg <= st.firstBit ? {{(WORD_W-1){1'b0}}, st.serBit} : '0;
      else if (st.shiftEn)
        shiftReg <= {shiftReg[WORD_W-2:0], st.serBit};
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import rxa_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bclkIn,
  input  logic              lrIn,
  input  logic              sdIn,
  input  logic [1:0]        fmtSel,
  input  logic              muteIn,
  output logic [WORD_W-1:0] leftOut,
  output logic [WORD_W-1:0] rightOut,
  output logic              sampleValid,
  output logic              muteOut
);
  logic [2:0] syncd;
  logic       bitRise;
  logic       lost;
  strobe_t    st;

  rxa_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) uSync (
    .clk(clk), .rstN(rstN), .din({sdIn, lrIn, bclkIn}), .dout(syncd)
  );

  rxa_watch #(.LOSS_CYCLES(LOSS_CYCLES)) uWatch (
    .clk(clk), .rstN(rstN), .bclkS(syncd[0]), .bitRise(bitRise), .lost(lost)
  );

  rxa_ctrl #(.WORD_W(WORD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bitRise(bitRise), .lost(lost),
    .lrS(syncd[1]), .dataS(syncd[2]), .fmtSel(fmtSel), .muteIn(muteIn),
    .st(st), .muteOut(muteOut)
  );

  rxa_datapath #(.WORD_W(WORD_W)) uData (
    .clk(clk), .rstN(rstN), .st(st),
    .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid)
  );
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_CYCLES = 1024
) (
  input logic              clk,
  input logic              rstN,
  input logic              bclkIn,
  input logic              muteIn,
  input logic [WORD_W-1:0] leftOut,
  input logic [WORD_W-1:0] rightOut,
  input logic              sampleValid,
  input logic              muteOut
);
  localparam int LIMIT = LOSS_CYCLES + SYNC_STAGES + 4;
  localparam int IW    = $clog2(LIMIT + 2) + 1;
  localparam logic [IW-1:0] LIMIT_V = IW'(LIMIT);

  logic          bclkSeen;
  logic [IW-1:0] idle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkSeen <= 1'b0;
      idle     <= '0;
    end else begin
      bclkSeen <= bclkIn;
      if (bclkIn != bclkSeen) idle <= '0;
      else if (idle != LIMIT_V) idle <= idle + 1'b1;
    end
  end

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(leftOut) && $stable(rightOut)));

  assert_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && $past(muteOut)) |-> (leftOut == '0 && rightOut == '0));

  assert_loss_R7: assert property (@(posedge clk) disable iff (!rstN)
    (idle == LIMIT_V) |-> muteOut);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(muteOut) |-> (sampleValid || $past(muteIn)));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(
  .WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES), .LOSS_CYCLES(LOSS_CYCLES)
) uChk (
  .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .muteIn(muteIn),
  .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid),
  .muteOut(muteOut)
);

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
  localparam int CLK_PERIOD = 10;
  localparam int LOSS       = 64;
  localparam int HALF_BCLK  = 4;
  localparam int NVEC       = 8;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [5:0]  n;
    logic [23:0] l;
    logic [23:0] r;
    logic        mute;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 6'd32, 24'h123456, 24'hABCDEF, 1'b0},
    '{2'd1, 6'd32, 24'h800001, 24'h7FFFFE, 1'b0},
    '{2'd2, 6'd32, 24'hF0F0F0, 24'h0F0F0F, 1'b0},
    '{2'd2, 6'd24, 24'hC3A55A, 24'h3C5AA5, 1'b0},
    '{2'd1, 6'd25, 24'hFFFFFF, 24'h000001, 1'b0},
    '{2'd0, 6'd24, 24'h5A5A5A, 24'hA5A5A5, 1'b1},
    '{2'd3, 6'd28, 24'h13579B, 24'h2468AC, 1'b0},
    '{2'd2, 6'd40, 24'h800000, 24'hFFFFFF, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bclkIn = 1'b0;
  logic        lrIn = 1'b0;
  logic        sdIn = 1'b0;
  logic [1:0]  fmtSel = 2'd0;
  logic        muteIn = 1'b0;
  logic [23:0] leftOut;
  logic [23:0] rightOut;
  logic        sampleValid;
  logic        muteOut;

  int total = 0;
  int bad = 0;
  int capCount = 0;
  int multi = 0;
  logic [23:0] capL = '0;
  logic [23:0] capR = '0;
  logic prevValid = 1'b0;
  logic done = 1'b0;

  serial_audio_rx #(.WORD_W(24), .SYNC_STAGES(2), .LOSS_CYCLES(LOSS)) u0 (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .lrIn(lrIn), .sdIn(sdIn),
    .fmtSel(fmtSel), .muteIn(muteIn), .leftOut(leftOut), .rightOut(rightOut),
    .sampleValid(sampleValid), .muteOut(muteOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (sampleValid) begin
      capL = leftOut;
      capR = rightOut;
      capCount = capCount + 1;
      if (prevValid) multi = multi + 1;
    end
    prevValid = sampleValid;
  end

  task automatic checkVal(input string tag, input string what, input int act, input int exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic slotBit(input logic [1:0] fmt, input int n,
                                   input logic [23:0] w, input int s);
    logic [23:0] t;
    logic junk;
    junk = ((s % 2) == 1);
    if (fmt == 2'd2) begin
      if (s >= n - 24) begin t = w >> (23 - (s - (n - 24))); return t[0]; end
      return junk;
    end else if (fmt == 2'd1) begin
      if (s >= 1 && s <= 24) begin t = w >> (24 - s); return t[0]; end
      return junk;
    end else begin
      if (s < 24) begin t = w >> (23 - s); return t[0]; end
      return junk;
    end
  endfunction

  task automatic bitOut(input logic lr, input logic d);
    @(negedge clk);
    bclkIn = 1'b0;
    lrIn = lr;
    sdIn = d;
    repeat (HALF_BCLK) @(negedge clk);
    bclkIn = 1'b1;
    repeat (HALF_BCLK - 1) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [1:0] fmt, input int n,
                           input logic [23:0] l, input logic [23:0] r);
    fmtSel = fmt;
    for (int s = 0; s < n; s++) bitOut(1'b0, slotBit(fmt, n, l, s));
    for (int s = 0; s < n; s++) bitOut(1'b1, slotBit(fmt, n, r, s));
  endtask

  function automatic string tagOf(input vec_t v);
    if (v.mute) return "R6";
    if (v.fmt == 2'd1) return "R3 R9";
    if (v.fmt == 2'd2) return "R4";
    return "R2 R9";
  endfunction

  initial begin
    repeat (HALF_BCLK * 100000) @(posedge clk);
    if (!done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int prevCount;
    // R1: reset state
    repeat (5) @(negedge clk);
    checkVal("R1", "leftOut in reset", int'(leftOut), 0);
    checkVal("R1", "sampleValid in reset", int'(sampleValid), 0);
    checkVal("R1", "muteOut in reset", int'(muteOut), 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkVal("R1", "rightOut after reset", int'(rightOut), 0);
    checkVal("R1", "muteOut after reset", int'(muteOut), 1);

    // R8: two warm-up frames, first emitted pair is zero
    sendFrame(2'd0, 32, 24'h111111, 24'h222222);
    sendFrame(2'd0, 32, 24'h333333, 24'h444444);
    checkVal("R8", "pairs after warm-up", capCount, 1);
    checkVal("R8", "first pair left", int'(capL), 0);
    checkVal("R8", "mute after first pair", int'(muteOut), 1);

    for (int i = 0; i < NVEC; i++) begin
      muteIn = (i > 0) ? VECS[i-1].mute : 1'b0;
      prevCount = capCount;
      sendFrame(VECS[i].fmt, int'(VECS[i].n), VECS[i].l, VECS[i].r);
      checkVal("R5", "one strobe per frame", capCount, prevCount + 1);
      if (i == 0) begin
        checkVal("R8", "second pair left", int'(capL), 0);
        checkVal("R8", "mute cleared", int'(muteOut), 0);
      end else begin
        checkVal(tagOf(VECS[i-1]), "left word", int'(capL),
                 VECS[i-1].mute ? 0 : int'(VECS[i-1].l));
        checkVal(tagOf(VECS[i-1]), "right word", int'(capR),
                 VECS[i-1].mute ? 0 : int'(VECS[i-1].r));
      end
      if (muteIn) checkVal("R6", "muteOut follows muteIn", int'(muteOut), 1);
    end
    muteIn = VECS[NVEC-1].mute;
    sendFrame(2'd0, 32, 24'h000000, 24'h000000);
    checkVal(tagOf(VECS[NVEC-1]), "left word", int'(capL), int'(VECS[NVEC-1].l));
    checkVal(tagOf(VECS[NVEC-1]), "right word", int'(capR), int'(VECS[NVEC-1].r));
    checkVal("R5", "no double strobe", multi, 0);
    checkVal("R8", "unmuted in steady state", int'(muteOut), 0);

    // R7: stop the bit clock
    muteIn = 1'b0;
    repeat (LOSS + 30) @(negedge clk);
    checkVal("R7", "muteOut after clock loss", int'(muteOut), 1);

    // R8: recovery over two emitted pairs
    sendFrame(2'd0, 32, 24'hAAAAAA, 24'h555555);
    checkVal("R7", "pair after loss left", int'(capL), 0);
    checkVal("R8", "still muted after first pair", int'(muteOut), 1);
    sendFrame(2'd0, 32, 24'h9ABCDE, 24'h6789AB);
    checkVal("R8", "second pair after loss left", int'(capL), 0);
    checkVal("R8", "second pair after loss right", int'(capR), 0);
    checkVal("R8", "mute cleared after loss", int'(muteOut), 0);
    sendFrame(2'd1, 32, 24'h000000, 24'h000000);
    checkVal("R8", "third pair left", int'(capL), 24'h9ABCDE);
    checkVal("R8", "third pair right", int'(capR), 24'h6789AB);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule